// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit control words that sits behind a plain register bus (word address, write strobe, write data, read strobe, read data) inside a 4 KB window. Software reaches clock and PLL settings, a reset-control word, a boot-mode word, an ID word and an array of pin-multiplexer words through it. The block holds only the register state; it has no effect on real clocks, PLLs or pins.

Nearly every write is gated by a lock. The block leaves reset locked. Software opens it by writing a 16-bit key to an unlock word and closes it by writing a different key to a lock word. Each implemented address has a fixed access class (read-write, read-only or write-only). Any access that breaks that class, any access to an unused address, and any write refused by the lock sets a sticky error flag. Writing a value with bit 0 set to the reset-control word, while the block is unlocked, stores the value and raises a one-cycle system reset request.

Top module: `sysctl_regs`

## Requirements
- R1: After reset these values hold: lock status (0x00C) reads 1, each PLL control word (0x100, 0x104, 0x108) reads 0x0001A008, PLL status (0x10C) reads 0x0000003F, boot mode (0x25C) reads 0x00000001, pin-mux words 2 to 8 (byte offsets 0x708 to 0x720) read 0x00000601, the other pin-mux words read 0x00001601, and err_o and sys_rst_req_o are 0.
- R2: A write to 0x008 clears lock status to 0 only if wdata bits 15:0 equal 0xDF0D. A write to 0x004 sets it to 1 only if bits 15:0 equal 0x767B. Bits 31:16 are not compared. A write with any other key leaves lock status unchanged and does not set err_o.
- R3: While lock status is 1, a write to any writable address other than 0x000, 0x004 and 0x008 leaves the stored word unchanged and sets err_o.
- R4: A write to 0x000 takes effect whether locked or not and stores only wdata bit 0; the word reads back as that bit with bits 31:1 zero.
- R5: The read-only addresses 0x00C, 0x10C, 0x25C and 0x530 discard writes, and such a write sets err_o.
- R6: The write-only addresses are 0x004, 0x008, 0x60C and 0x614. Writing one of them does not set err_o. A read from one sets err_o and returns the stored word: the last value written to 0x60C or 0x614, and 0 for 0x004 and 0x008.
- R7: A read from an unimplemented address returns 0 and sets err_o. A write to an unimplemented address changes nothing and sets err_o.
- R8: A write to 0x200 while unlocked stores the full word. If wdata bit 0 is 1, sys_rst_req_o is 1 for exactly the one cycle after the write edge. A write with bit 0 clear, or one refused by the lock, gives no pulse.
- R9: rdata_o is registered. It shows the addressed word in the cycle after the edge at which rd_en_i is sampled, and keeps its value in cycles with no read, writes included.
- R10: err_o stays at 1 once it is set, until rst_ni is asserted.
- R11: The 54 pin-mux words at 0x700 to 0x7D4 are read-write while unlocked, and a write to one of them leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address in the window; bits 1:0 are ignored |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| err_o | output | 1 | Sticky access-error flag |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench presents keys that match in the low 16 bits but carry junk above them, and keys that are one bit off. A design that compares all 32 bits would stay locked, and one that accepts near misses would open. Each access class is checked on its own, starting from reset, so err_o is clean each time. A design that applies the lock to the key registers or to 0x000, lets locked writes through silently, returns 0 for a write-only read, or stores writes to read-only words will show a wrong readback or a wrong err_o. The reset request is sampled in the cycle after the write and in the cycle after that. This catches a missing pulse, a level that stays high, and a pulse that fires while the block is locked or when bit 0 is clear.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  typedef enum logic [3:0] {
    K_NONE, K_SCR, K_LOCK, K_UNLOCK, K_LSTAT, K_PLL, K_PSTAT,
    K_CLK, K_RST, K_BOOT, K_ID, K_CAL, K_REF, K_PIN
  } kind_e;

  typedef struct packed {
    acc_e       acc;
    kind_e      kind;
    logic [7:0] idx;
  } dec_t;

  // word indices (byte offset / 4)
  localparam logic [9:0] W_SCR    = 10'h000;
  localparam logic [9:0] W_LOCK   = 10'h001;
  localparam logic [9:0] W_UNLOCK = 10'h002;
  localparam logic [9:0] W_LSTAT  = 10'h003;
  localparam logic [9:0] W_PLL    = 10'h040;
  localparam logic [9:0] W_PSTAT  = 10'h043;
  localparam logic [9:0] W_CLK    = 10'h048;
  localparam logic [9:0] W_RST    = 10'h080;
  localparam logic [9:0] W_BOOT   = 10'h097;
  localparam logic [9:0] W_ID     = 10'h14C;
  localparam logic [9:0] W_CAL    = 10'h183;
  localparam logic [9:0] W_REF    = 10'h185;
  localparam logic [9:0] W_PIN    = 10'h1C0;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NUM_PLL = 3,
  parameter int NUM_CLK = 4,
  parameter int NUM_PIN = 54
) (
  input  logic [9:0] widx_i,
  output dec_t       dec_o
);
  logic [9:0] d_pll, d_clk, d_pin;

  always_comb begin
    d_pll = widx_i - W_PLL;
    d_clk = widx_i - W_CLK;
    d_pin = widx_i - W_PIN;
    dec_o = '{acc: ACC_NONE, kind: K_NONE, idx: '0};
    if (widx_i == W_SCR)         dec_o = '{ACC_RW, K_SCR, 8'd0};
    else if (widx_i == W_LOCK)   dec_o = '{ACC_WO, K_LOCK, 8'd0};
    else if (widx_i == W_UNLOCK) dec_o = '{ACC_WO, K_UNLOCK, 8'd0};
    else if (widx_i == W_LSTAT)  dec_o = '{ACC_RO, K_LSTAT, 8'd0};
    else if (widx_i == W_PSTAT)  dec_o = '{ACC_RO, K_PSTAT, 8'd0};
    else if (widx_i == W_RST)    dec_o = '{ACC_RW, K_RST, 8'd0};
    else if (widx_i == W_BOOT)   dec_o = '{ACC_RO, K_BOOT, 8'd0};
    else if (widx_i == W_ID)     dec_o = '{ACC_RO, K_ID, 8'd0};
    else if (widx_i == W_CAL)    dec_o = '{ACC_WO, K_CAL, 8'd0};
    else if (widx_i == W_REF)    dec_o = '{ACC_WO, K_REF, 8'd0};
    else if (d_pll < 10'(NUM_PLL)) dec_o = '{ACC_RW, K_PLL, d_pll[7:0]};
    else if (d_clk < 10'(NUM_CLK)) dec_o = '{ACC_RW, K_CLK, d_clk[7:0]};
    else if (d_pin < 10'(NUM_PIN)) dec_o = '{ACC_RW, K_PIN, d_pin[7:0]};
  end
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        close_we_i,
  input  logic        open_we_i,
  input  logic [15:0] key_i,
  output logic        locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  locked_o <= 1'b1;
    else if (close_we_i && key_i == KEY_CLOSE)    locked_o <= 1'b1;
    else if (open_we_i && key_i == KEY_OPEN)      locked_o <= 1'b0;
  end

  p_open_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(open_we_i && key_i == KEY_OPEN));
  p_close_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(close_we_i && key_i == KEY_CLOSE));
endmodule

// File: rtl/sysctl_pinmux.sv
module sysctl_pinmux #(
  parameter int          NUM_PIN = 54,
  parameter int          ALT_LO  = 2,
  parameter int          ALT_HI  = 8,
  parameter logic [31:0] DEF_VAL = 32'h0000_1601,
  parameter logic [31:0] ALT_VAL = 32'h0000_0601
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  idx_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  logic [31:0] mux_q [NUM_PIN];

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_word
    localparam logic [31:0] RST_VAL = (g >= ALT_LO && g <= ALT_HI) ? ALT_VAL : DEF_VAL;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mux_q[g] <= RST_VAL;
      else if (we_i && idx_i == 8'(g))    mux_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(idx_i) < NUM_PIN) ? mux_q[idx_i] : '0;

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mux_q[0]) && $stable(mux_q[NUM_PIN-1]));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          NUM_PLL  = 3,
  parameter int          NUM_CLK  = 4,
  parameter int          NUM_PIN  = 54,
  parameter logic [31:0] PLL_INIT = 32'h0001_A008,
  parameter logic [31:0] PST_INIT = 32'h0000_003F,
  parameter logic [31:0] BOOT_VAL = 32'h0000_0001,
  parameter logic [31:0] ID_VAL   = 32'h1A5C_0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [11:0] addr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  input  logic        rd_en_i,
  output logic [31:0] rdata_o,
  output logic        err_o,
  output logic        sys_rst_req_o
);
  dec_t        dec;
  logic        locked;
  logic        key_kind, writable, blocked, commit, err_set;
  logic        scr_q;
  logic [31:0] pll_q [NUM_PLL];
  logic [31:0] clk_q [NUM_CLK];
  logic [31:0] rst_q, cal_q, ref_q, pin_rd, rd_word;

  sysctl_decode #(.NUM_PLL(NUM_PLL), .NUM_CLK(NUM_CLK), .NUM_PIN(NUM_PIN)) u_dec (
    .widx_i (addr_i[11:2]),
    .dec_o  (dec)
  );

  sysctl_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .close_we_i (wr_en_i && dec.kind == K_LOCK),
    .open_we_i  (wr_en_i && dec.kind == K_UNLOCK),
    .key_i      (wdata_i[15:0]),
    .locked_o   (locked)
  );

  // key words and the scratch bit bypass the lock
  assign key_kind = dec.kind inside {K_SCR, K_LOCK, K_UNLOCK};
  assign writable = dec.acc inside {ACC_RW, ACC_WO};
  assign blocked  = locked && writable && !key_kind;
  assign commit   = wr_en_i && writable && !blocked;
  assign err_set  = (wr_en_i && (dec.acc inside {ACC_RO, ACC_NONE} || blocked))
                 || (rd_en_i && dec.acc inside {ACC_WO, ACC_NONE});

  sysctl_pinmux #(.NUM_PIN(NUM_PIN)) u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit && dec.kind == K_PIN),
    .idx_i   (dec.idx),
    .wdata_i (wdata_i),
    .rdata_o (pin_rd)
  );

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          pll_q[g] <= PLL_INIT;
      else if (commit && dec.kind == K_PLL && dec.idx == 8'(g)) pll_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          clk_q[g] <= '0;
      else if (commit && dec.kind == K_CLK && dec.idx == 8'(g)) clk_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scr_q <= 1'b0;
      rst_q <= '0;
      cal_q <= '0;
      ref_q <= '0;
    end else if (commit) begin
      case (dec.kind)
        K_SCR:   scr_q <= wdata_i[0];
        K_RST:   rst_q <= wdata_i;
        K_CAL:   cal_q <= wdata_i;
        K_REF:   ref_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dec.kind)
      K_SCR:   rd_word = {31'd0, scr_q};
      K_LSTAT: rd_word = {31'd0, locked};
      K_PLL:   rd_word = pll_q[dec.idx];
      K_PSTAT: rd_word = PST_INIT;
      K_CLK:   rd_word = clk_q[dec.idx];
      K_RST:   rd_word = rst_q;
      K_BOOT:  rd_word = BOOT_VAL;
      K_ID:    rd_word = ID_VAL;
      K_CAL:   rd_word = cal_q;
      K_REF:   rd_word = ref_q;
      K_PIN:   rd_word = pin_rd;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o       <= '0;
      err_o         <= 1'b0;
      sys_rst_req_o <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_word;
      if (err_set) err_o   <= 1'b1;
      sys_rst_req_o <= commit && dec.kind == K_RST && wdata_i[0];
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_blocked_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && locked && dec.kind == K_PLL) |=> err_o && $stable(pll_q[0]));
  p_ro_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && dec.acc == ACC_RO) |=> err_o);
  p_rst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(wr_en_i && addr_i[11:2] == W_RST && wdata_i[0] && !locked));
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  logic        clk = 0, rst_ni = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, rreq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  sysctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .err_o(err),
    .sys_rst_req_o(rreq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v === e, tag, v, e);
  endtask

  task automatic t_reset_values();
    do_reset();
    chk(err === 1'b0 && rreq === 1'b0, "R1 err/req after reset", {30'd0, err, rreq}, 32'd0);
    expect_rd(12'h00C, 32'h1, "R1 lock status");
    expect_rd(12'h100, 32'h0001A008, "R1 pll0");
    expect_rd(12'h108, 32'h0001A008, "R1 pll2");
    expect_rd(12'h10C, 32'h3F, "R1 pll status");
    expect_rd(12'h25C, 32'h1, "R1 boot mode");
    expect_rd(12'h704, 32'h1601, "R1 pin1");
    expect_rd(12'h708, 32'h0601, "R1 pin2");
    expect_rd(12'h720, 32'h0601, "R1 pin8");
    expect_rd(12'h724, 32'h1601, "R1 pin9");
    expect_rd(12'h7D4, 32'h1601, "R1 pin53");
    chk(err === 1'b0, "R1 no err on legal reads", {31'd0, err}, 32'd0);
  endtask

  task automatic t_lock_keys();
    do_reset();
    wr(12'h008, 32'h0000DF0C);
    expect_rd(12'h00C, 32'h1, "R2 wrong open key ignored");
    wr(12'h008, 32'hABCDDF0D);
    expect_rd(12'h00C, 32'h0, "R2 open key, upper bits junk");
    wr(12'h004, 32'h0000767A);
    expect_rd(12'h00C, 32'h0, "R2 wrong close key ignored");
    wr(12'h004, 32'h5555767B);
    expect_rd(12'h00C, 32'h1, "R2 close key");
    chk(err === 1'b0, "R2 key writes raise no err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_locked_writes();
    do_reset();
    wr(12'h100, 32'h12345678);
    chk(err === 1'b1, "R3 locked write sets err", {31'd0, err}, 32'd1);
    expect_rd(12'h100, 32'h0001A008, "R3 locked pll unchanged");
    wr(12'h700, 32'hDEAD);
    expect_rd(12'h700, 32'h1601, "R3 locked pin unchanged");
    wr(12'h008, 32'hDF0D);
    wr(12'h100, 32'h12345678);
    expect_rd(12'h100, 32'h12345678, "R3 unlocked pll write lands");
    chk(err === 1'b1, "R10 err still set", {31'd0, err}, 32'd1);
  endtask

  task automatic t_scratch();
    do_reset();
    wr(12'h000, 32'hFFFFFFFF);
    expect_rd(12'h000, 32'h1, "R4 scratch keeps bit0 while locked");
    wr(12'h000, 32'hFFFFFFFE);
    expect_rd(12'h000, 32'h0, "R4 scratch cleared");
    chk(err === 1'b0, "R4 scratch no err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_readonly();
    do_reset();
    wr(12'h008, 32'hDF0D);
    wr(12'h25C, 32'hFF);
    chk(err === 1'b1, "R5 ro write sets err", {31'd0, err}, 32'd1);
    expect_rd(12'h25C, 32'h1, "R5 boot unchanged");
    wr(12'h10C, 32'h0);
    expect_rd(12'h10C, 32'h3F, "R5 pll status unchanged");
    wr(12'h00C, 32'h1);
    expect_rd(12'h00C, 32'h0, "R5 lock status unchanged");
  endtask

  task automatic t_writeonly();
    do_reset();
    wr(12'h008, 32'hDF0D);
    wr(12'h60C, 32'hCAFE0001);
    chk(err === 1'b0, "R6 wo write no err", {31'd0, err}, 32'd0);
    expect_rd(12'h60C, 32'hCAFE0001, "R6 wo read returns stored");
    chk(err === 1'b1, "R6 wo read sets err", {31'd0, err}, 32'd1);
    expect_rd(12'h004, 32'h0, "R6 lock word reads 0");
  endtask

  task automatic t_unimpl();
    do_reset();
    wr(12'h008, 32'hDF0D);
    expect_rd(12'h800, 32'h0, "R7 unimpl read 0");
    chk(err === 1'b1, "R7 unimpl read err", {31'd0, err}, 32'd1);
    do_reset();
    wr(12'h008, 32'hDF0D);
    wr(12'hFFC, 32'h1234);
    chk(err === 1'b1, "R7 unimpl write err", {31'd0, err}, 32'd1);
    expect_rd(12'hFFC, 32'h0, "R7 unimpl write not stored");
  endtask

  task automatic t_softreset();
    do_reset();
    wr(12'h008, 32'hDF0D);
    wr(12'h200, 32'h2);
    chk(rreq === 1'b0, "R8 no pulse bit0 clear", {31'd0, rreq}, 32'd0);
    wr(12'h200, 32'h00000201);
    chk(rreq === 1'b1, "R8 pulse after write", {31'd0, rreq}, 32'd1);
    @(negedge clk);
    chk(rreq === 1'b0, "R8 pulse one cycle", {31'd0, rreq}, 32'd0);
    expect_rd(12'h200, 32'h201, "R8 reset word stored");
    chk(err === 1'b0, "R8 no err", {31'd0, err}, 32'd0);
    wr(12'h004, 32'h767B);
    wr(12'h200, 32'h1);
    chk(rreq === 1'b0, "R8 no pulse while locked", {31'd0, rreq}, 32'd0);
  endtask

  task automatic t_pinmux_latency();
    logic [31:0] v;
    do_reset();
    wr(12'h008, 32'hDF0D);
    wr(12'h7D0, 32'hAAAA5555);
    expect_rd(12'h7D0, 32'hAAAA5555, "R11 pin52 written");
    expect_rd(12'h7CC, 32'h1601, "R11 pin51 untouched");
    expect_rd(12'h7D4, 32'h1601, "R11 pin53 untouched");
    wr(12'h7D4, 32'h77);
    chk(rdata === 32'h1601, "R9 rdata holds across write", rdata, 32'h1601);
    @(negedge clk); addr = 12'h7D4; rd_en = 1;
    chk(rdata === 32'h1601, "R9 rdata not yet updated", rdata, 32'h1601);
    @(negedge clk); rd_en = 0; v = rdata;
    chk(v === 32'h77, "R9 rdata one cycle later", v, 32'h77);
  endtask

  initial begin
    t_reset_values();
    t_lock_keys();
    t_locked_writes();
    t_scratch();
    t_readonly();
    t_writeonly();
    t_unimpl();
    t_softreset();
    t_pinmux_latency();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule